// File: doc/BRIEF.md
# Mode-Resolving Scratch RAM for an 8-bit Controller

This block holds the 256-byte working RAM of a small 8-bit processor core. It decides where each access lands from two things: the byte address and the addressing mode the instruction used. Four request ports reach it:

- a working-register port, which takes a 3-bit register index and is relocated by a 2-bit bank selector;
- a direct port;
- an indirect port;
- a single-bit port.

Indirect accesses reach all 256 bytes. Direct accesses reach the lower half only. A direct address with its top bit set goes out on a separate special-register bus, and the upper RAM bytes are left alone. Bit addresses below 0x80 select one bit inside bytes 0x20–0x2F. The block performs a bit write as a read-modify-write within a single cycle. Bit addresses from 0x80 upward also go to the special-register bus.

One access is served per cycle. A fixed priority picks the winner and the block reports it on a grant line per port. Reads are combinational from the stored bytes. Writes land on the rising clock edge. The storage is never cleared.

Top module: `iram_core`

## Requirements
- R1: A direct access to an address 0x00–0x7F reads or writes the same RAM byte that an indirect access to that address reaches.
- R2: An indirect access reaches RAM at every address 0x00–0xFF and never asserts `sfr_req`. Bytes 0x80–0xFF are unaffected by direct writes.
- R3: A granted direct access to an address 0x80–0xFF asserts `sfr_req` with `sfr_bit`=0 and drives `sfr_addr`, `sfr_we` and `sfr_wdata` from the direct port. `dir_rdata` then returns `sfr_rdata`.
- R4: Register index n with bank b addresses RAM byte {b, n}, so that byte = 8*b + n.
- R5: A bit address a below 0x80 selects byte 0x20 + a[6:3], bit a[2:0]. `bit_rdata` returns that bit.
- R6: A bit write to RAM changes only the selected bit. The other seven bits of that byte keep their values.
- R7: A bit address of 0x80 or above asserts `sfr_req` with `sfr_bit`=1 and `sfr_addr` = the bit address. The written value travels in `sfr_wdata[0]`, with the other bits zero, and `bit_rdata` returns `sfr_rdata[0]`.
- R8: When several ports request at once, exactly one is granted, in the order register, direct, indirect, bit. A losing port's access has no effect, and its read data is zero.
- R9: A write takes effect at the rising clock edge. In the cycle of the write, the port's read data shows the previous contents.
- R10: While `rst` is high, no port is granted, `sfr_req` stays low and no RAM byte changes. The RAM contents survive reset.
- R11: When no granted access targets the special-register bus, `sfr_req`, `sfr_we`, `sfr_bit`, `sfr_addr` and `sfr_wdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Active register bank |
| reg_req | input | 1 | Register port request |
| reg_we | input | 1 | Register port write enable |
| reg_idx | input | 3 | Register index within bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_gnt | output | 1 | Register port served this cycle |
| dir_req | input | 1 | Direct port request |
| dir_we | input | 1 | Direct port write enable |
| dir_addr | input | 8 | Direct byte address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| dir_gnt | output | 1 | Direct port served this cycle |
| ind_req | input | 1 | Indirect port request |
| ind_we | input | 1 | Indirect port write enable |
| ind_addr | input | 8 | Indirect byte address |
| ind_wdata | input | 8 | Indirect write data |
| ind_rdata | output | 8 | Indirect read data |
| ind_gnt | output | 1 | Indirect port served this cycle |
| bit_req | input | 1 | Bit port request |
| bit_we | input | 1 | Bit port write enable |
| bit_addr | input | 8 | Bit address |
| bit_wval | input | 1 | Bit value to write |
| bit_rdata | output | 1 | Bit read value |
| bit_gnt | output | 1 | Bit port served this cycle |
| sfr_req | output | 1 | Special-register bus access |
| sfr_we | output | 1 | Special-register bus write |
| sfr_bit | output | 1 | Access is a single-bit one |
| sfr_addr | output | 8 | Special-register byte or bit address |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data |

## Verification
Directed cases write through one mode and read back through another:

- a register in bank 2 read back directly;
- a bit set read back as a byte;
- a direct write to 0x90 followed by an indirect read of 0x90, which tells the RAM and special-register spaces apart.

Reset is pulsed with requests pending, which shows that nothing is granted and that the stored bytes persist. Random cycles then raise any mix of the four requests with random addresses, banks and write data. Collisions exercise the priority order. Random bit writes show whether the seven neighbouring bits are disturbed. Same-cycle read data on writes shows whether the update is delayed to the clock edge.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int NPORT  = 4;
  localparam int P_REG  = 0;
  localparam int P_DIR  = 1;
  localparam int P_IND  = 2;
  localparam int P_BIT  = 3;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] wdata;
  } acc_t;

  typedef struct packed {
    logic       to_sfr;
    logic       is_bit;
    logic [7:0] ram_addr;
    logic [2:0] bit_pos;
  } route_t;
endpackage

// File: rtl/iram_arb.sv
module iram_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/iram_map.sv
module iram_map
  import iram_pkg::*;
#(
  parameter int          BANK_W   = 2,
  parameter int          RIDX_W   = 3,
  parameter logic [7:0]  BIT_BASE = 8'h20
) (
  input  logic [NPORT-1:0]  gnt,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [7:0]        dir_addr,
  input  logic [7:0]        ind_addr,
  input  logic [7:0]        bit_addr,
  output route_t            rt
);
  localparam int REG_AW = BANK_W + RIDX_W;

  always_comb begin
    rt = '0;
    unique case (1'b1)
      gnt[P_REG]: rt.ram_addr = 8'({bank_sel, reg_idx});
      gnt[P_DIR]: begin
        rt.ram_addr = dir_addr;
        rt.to_sfr   = dir_addr[7];
      end
      gnt[P_IND]: rt.ram_addr = ind_addr;
      gnt[P_BIT]: begin
        rt.is_bit   = 1'b1;
        rt.to_sfr   = bit_addr[7];
        rt.ram_addr = BIT_BASE + 8'(bit_addr[6:3]);
        rt.bit_pos  = bit_addr[2:0];
      end
      default: rt = '0;
    endcase
  end

  if (REG_AW > 8) begin : g_bad
    initial $error("register window wider than address");
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/iram_core.sv
module iram_core
  import iram_pkg::*;
#(
  parameter int         BANK_W   = 2,
  parameter int         RIDX_W   = 3,
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              reg_gnt,
  input  logic              dir_req,
  input  logic              dir_we,
  input  logic [7:0]        dir_addr,
  input  logic [7:0]        dir_wdata,
  output logic [7:0]        dir_rdata,
  output logic              dir_gnt,
  input  logic              ind_req,
  input  logic              ind_we,
  input  logic [7:0]        ind_addr,
  input  logic [7:0]        ind_wdata,
  output logic [7:0]        ind_rdata,
  output logic              ind_gnt,
  input  logic              bit_req,
  input  logic              bit_we,
  input  logic [7:0]        bit_addr,
  input  logic              bit_wval,
  output logic              bit_rdata,
  output logic              bit_gnt,
  output logic              sfr_req,
  output logic              sfr_we,
  output logic              sfr_bit,
  output logic [7:0]        sfr_addr,
  output logic [7:0]        sfr_wdata,
  input  logic [7:0]        sfr_rdata
);
  localparam int DEPTH = 256;

  logic [NPORT-1:0] req, gnt;
  acc_t             port_acc [NPORT];
  acc_t             sel;
  route_t           rt;
  logic             any_gnt;
  logic [7:0]       mem_rdata, mem_wdata, byte_rd, bit_mask;
  logic             mem_we, bit_rd;

  assign req = {bit_req, ind_req, dir_req, reg_req} & {NPORT{~rst}};

  iram_arb #(.N(NPORT)) u_arb (.req(req), .gnt(gnt));

  assign port_acc[P_REG] = '{we: reg_we, addr: 8'({bank_sel, reg_idx}), wdata: reg_wdata};
  assign port_acc[P_DIR] = '{we: dir_we, addr: dir_addr, wdata: dir_wdata};
  assign port_acc[P_IND] = '{we: ind_we, addr: ind_addr, wdata: ind_wdata};
  assign port_acc[P_BIT] = '{we: bit_we, addr: bit_addr, wdata: {7'd0, bit_wval}};

  always_comb begin
    sel = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (gnt[i]) sel = port_acc[i];
    end
  end

  assign any_gnt = |gnt;

  iram_map #(.BANK_W(BANK_W), .RIDX_W(RIDX_W), .BIT_BASE(BIT_BASE)) u_map (
    .gnt      (gnt),
    .bank_sel (bank_sel),
    .reg_idx  (reg_idx),
    .dir_addr (dir_addr),
    .ind_addr (ind_addr),
    .bit_addr (bit_addr),
    .rt       (rt)
  );

  assign bit_mask  = 8'd1 << rt.bit_pos;
  assign mem_wdata = rt.is_bit ? ((mem_rdata & ~bit_mask) | ({8{sel.wdata[0]}} & bit_mask))
                               : sel.wdata;
  assign mem_we    = any_gnt & sel.we & ~rt.to_sfr;

  iram_store #(.DW(8), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (rt.ram_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  // special-register bus, quiet unless an access is routed there
  assign sfr_req   = any_gnt & rt.to_sfr;
  assign sfr_we    = sfr_req & sel.we;
  assign sfr_bit   = sfr_req & rt.is_bit;
  assign sfr_addr  = sfr_req ? sel.addr : 8'd0;
  assign sfr_wdata = sfr_req ? sel.wdata : 8'd0;

  assign byte_rd = rt.to_sfr ? sfr_rdata : mem_rdata;
  assign bit_rd  = rt.to_sfr ? sfr_rdata[0] : mem_rdata[rt.bit_pos];

  assign reg_gnt   = gnt[P_REG];
  assign dir_gnt   = gnt[P_DIR];
  assign ind_gnt   = gnt[P_IND];
  assign bit_gnt   = gnt[P_BIT];
  assign reg_rdata = gnt[P_REG] ? byte_rd : 8'd0;
  assign dir_rdata = gnt[P_DIR] ? byte_rd : 8'd0;
  assign ind_rdata = gnt[P_IND] ? byte_rd : 8'd0;
  assign bit_rdata = gnt[P_BIT] & bit_rd;
endmodule

// File: rtl/iram_chk.sv
module iram_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_req,
  input logic       dir_req,
  input logic       dir_we,
  input logic [7:0] dir_addr,
  input logic       ind_req,
  input logic       ind_we,
  input logic [7:0] ind_addr,
  input logic [7:0] ind_wdata,
  input logic [7:0] ind_rdata,
  input logic       bit_req,
  input logic [7:0] bit_addr,
  input logic       reg_gnt,
  input logic       dir_gnt,
  input logic       ind_gnt,
  input logic       bit_gnt,
  input logic       sfr_req,
  input logic       sfr_bit,
  input logic       sfr_we,
  input logic [7:0] sfr_addr
);
  a_r8_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_gnt, dir_gnt, ind_gnt, bit_gnt}));

  a_r8_reg_first: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> reg_gnt);

  a_r8_dir_second: assert property (@(posedge clk) disable iff (rst)
    (dir_req && !reg_req) |-> dir_gnt);

  a_r8_ind_third: assert property (@(posedge clk) disable iff (rst)
    (ind_req && !reg_req && !dir_req) |-> ind_gnt);

  a_r8_bit_last: assert property (@(posedge clk) disable iff (rst)
    (bit_req && !reg_req && !dir_req && !ind_req) |-> bit_gnt);

  a_r3_dir_upper_fwd: assert property (@(posedge clk) disable iff (rst)
    (dir_gnt && dir_addr[7]) |-> (sfr_req && !sfr_bit && sfr_addr == dir_addr && sfr_we == dir_we));

  a_r1_dir_lower_ram: assert property (@(posedge clk) disable iff (rst)
    (dir_gnt && !dir_addr[7]) |-> !sfr_req);

  a_r2_ind_no_sfr: assert property (@(posedge clk) disable iff (rst)
    ind_gnt |-> !sfr_req);

  a_r7_bit_upper_fwd: assert property (@(posedge clk) disable iff (rst)
    (bit_gnt && bit_addr[7]) |-> (sfr_req && sfr_bit && sfr_addr == bit_addr));

  a_r9_write_then_read: assert property (@(posedge clk) disable iff (rst)
    ($past(ind_gnt && ind_we) && ind_gnt && !ind_we && ind_addr == $past(ind_addr))
      |-> ind_rdata == $past(ind_wdata));

  a_r11_sfr_needs_grant: assert property (@(posedge clk) disable iff (rst)
    sfr_req |-> (dir_gnt || bit_gnt));

  always_comb begin
    if (rst) begin
      a_r10_reset_quiet: assert (!(reg_gnt || dir_gnt || ind_gnt || bit_gnt || sfr_req));
    end
  end
endmodule

bind iram_core iram_chk u_chk (.*);

// File: tb/sim_iram_core.sv
module sim_iram_core;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bank_sel;
  logic       reg_req, reg_we, reg_gnt;
  logic [2:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic       dir_req, dir_we, dir_gnt;
  logic [7:0] dir_addr, dir_wdata, dir_rdata;
  logic       ind_req, ind_we, ind_gnt;
  logic [7:0] ind_addr, ind_wdata, ind_rdata;
  logic       bit_req, bit_we, bit_wval, bit_rdata, bit_gnt;
  logic [7:0] bit_addr;
  logic       sfr_req, sfr_we, sfr_bit;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [256];

  always #4 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'hA5;

  iram_core u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_req = 0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
    dir_req = 0; dir_we = 0; dir_addr = 0; dir_wdata = 0;
    ind_req = 0; ind_we = 0; ind_addr = 0; ind_wdata = 0;
    bit_req = 0; bit_we = 0; bit_addr = 0; bit_wval = 0;
  endtask

  function automatic logic [7:0] bit_byte(input logic [7:0] a);
    return 8'h20 + 8'(a[6:3]);
  endfunction

  // inputs are already driven (at negedge); check mid-low phase, then clock and update model
  task automatic step();
    int win;
    logic [7:0] ra, eb;
    logic       to_sfr, eb1;
    #2;
    win = reg_req ? 0 : dir_req ? 1 : ind_req ? 2 : bit_req ? 3 : 4;
    chk("R8 grants", {reg_gnt, dir_gnt, ind_gnt, bit_gnt},
        {win == 0, win == 1, win == 2, win == 3});
    to_sfr = (win == 1 && dir_addr[7]) || (win == 3 && bit_addr[7]);
    chk("R11 sfr_req", sfr_req, to_sfr);
    if (!to_sfr)
      chk("R11 sfr quiet", {sfr_we, sfr_bit, sfr_addr, sfr_wdata}, 0);
    case (win)
      0: begin
        ra = {3'b0, bank_sel, reg_idx};
        chk("R4 R9 reg_rdata", reg_rdata, mdl[ra]);
        chk("R8 others zero", {dir_rdata, ind_rdata, bit_rdata}, 0);
      end
      1: begin
        if (dir_addr[7]) begin
          chk("R3 sfr fwd", {sfr_we, sfr_bit, sfr_addr, sfr_wdata},
              {dir_we, 1'b0, dir_addr, dir_wdata});
          chk("R3 dir_rdata sfr", dir_rdata, dir_addr ^ 8'hA5);
        end else
          chk("R1 R9 dir_rdata", dir_rdata, mdl[dir_addr]);
        chk("R8 others zero", {reg_rdata, ind_rdata, bit_rdata}, 0);
      end
      2: begin
        chk("R2 R9 ind_rdata", ind_rdata, mdl[ind_addr]);
        chk("R8 others zero", {reg_rdata, dir_rdata, bit_rdata}, 0);
      end
      3: begin
        if (bit_addr[7]) begin
          chk("R7 sfr bit fwd", {sfr_we, sfr_bit, sfr_addr, sfr_wdata},
              {bit_we, 1'b1, bit_addr, 7'd0, bit_wval});
          chk("R7 bit_rdata sfr", bit_rdata, bit_addr[0] ^ 1'b1);
        end else begin
          eb = mdl[bit_byte(bit_addr)];
          eb1 = eb[bit_addr[2:0]];
          chk("R5 bit_rdata", bit_rdata, eb1);
        end
        chk("R8 others zero", {reg_rdata, dir_rdata, ind_rdata}, 0);
      end
      default: chk("R8 idle zero", {reg_rdata, dir_rdata, ind_rdata, bit_rdata}, 0);
    endcase
    @(posedge clk);
    case (win)
      0: if (reg_we) mdl[{3'b0, bank_sel, reg_idx}] = reg_wdata;
      1: if (dir_we && !dir_addr[7]) mdl[dir_addr] = dir_wdata;
      2: if (ind_we) mdl[ind_addr] = ind_wdata;
      3: if (bit_we && !bit_addr[7]) mdl[bit_byte(bit_addr)][bit_addr[2:0]] = bit_wval;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic ind_wr(input logic [7:0] a, input logic [7:0] d);
    idle(); ind_req = 1; ind_we = 1; ind_addr = a; ind_wdata = d; step();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h1234_5678));
    idle(); bank_sel = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 256; i++) ind_wr(8'(i), 8'($urandom));

    // R10: requests during reset are ignored, contents survive
    rst = 1;
    idle(); ind_req = 1; ind_we = 1; ind_addr = 8'h40; ind_wdata = ~mdl[8'h40];
    dir_req = 1; dir_addr = 8'h85; bit_req = 1; bit_addr = 8'h90;
    #2;
    chk("R10 no grant in reset", {reg_gnt, dir_gnt, ind_gnt, bit_gnt, sfr_req}, 0);
    @(negedge clk);
    rst = 0; idle(); ind_req = 1; ind_addr = 8'h40; step();

    // R4 + R1: register bank 2, r5 -> byte 0x15 seen by direct read
    idle(); bank_sel = 2; reg_req = 1; reg_we = 1; reg_idx = 5; reg_wdata = 8'h3C; step();
    idle(); dir_req = 1; dir_addr = 8'h15; step();
    chk("R4 bank2 r5 at 0x15", mdl[8'h15], 8'h3C);

    // R5/R6: bit 0x0B -> byte 0x21 bit 3
    idle(); dir_req = 1; dir_we = 1; dir_addr = 8'h21; dir_wdata = 8'h00; step();
    idle(); bit_req = 1; bit_we = 1; bit_addr = 8'h0B; bit_wval = 1; step();
    idle(); ind_req = 1; ind_addr = 8'h21; #2;
    chk("R6 only bit 3 set", ind_rdata, 8'h08);
    step();

    // R2/R3: direct write 0x90 goes to special bus, RAM 0x90 intact
    b = mdl[8'h90];
    idle(); dir_req = 1; dir_we = 1; dir_addr = 8'h90; dir_wdata = ~b; step();
    idle(); ind_req = 1; ind_addr = 8'h90; #2;
    chk("R2 upper RAM untouched", ind_rdata, b);
    step();

    // R9: same-cycle read shows old value
    idle(); ind_req = 1; ind_we = 1; ind_addr = 8'hC3; ind_wdata = ~mdl[8'hC3]; step();

    for (int n = 0; n < 4000; n++) begin
      idle();
      bank_sel = 2'($urandom);
      {reg_req, dir_req, ind_req, bit_req} = 4'($urandom) & 4'($urandom);
      reg_we = 1'($urandom); reg_idx = 3'($urandom); reg_wdata = 8'($urandom);
      dir_we = 1'($urandom); dir_addr = 8'($urandom); dir_wdata = 8'($urandom);
      ind_we = 1'($urandom); ind_addr = 8'($urandom); ind_wdata = 8'($urandom);
      bit_we = 1'($urandom); bit_addr = 8'($urandom); bit_wval = 1'($urandom);
      step();
    end

    // final sweep of all bytes
    for (int i = 0; i < 256; i++) begin
      idle(); ind_req = 1; ind_addr = 8'(i); step();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule